// File: doc/BRIEF.md
# Signed Sliding-Window Median Filter

This block cleans impulsive noise from a stream of signed samples. It takes one two's complement sample on every rising clock edge. There is no handshake, so the stream runs at the full clock rate. The filter keeps the seven newest samples and produces the value that ranks fourth among them. An isolated spike of either polarity therefore never reaches the output.

Each new sample is included in the ranking in the same cycle that it arrives. The chosen value is registered, so the median of any window appears one cycle after the edge that completed that window. After reset the block waits until seven fresh samples are held and raises its valid strobe only then. No result is ever produced from a partly filled window. A synchronous reset clears the history and the fill count, so no sample taken before the reset can affect a later result.

Top module: `sliding_median_filter`

## Requirements
- R1: On the edge after any clock edge at which `rst` is high, `dout_valid` reads 0 and `dout` reads 0.
- R2: After reset is released, `dout_valid` stays 0 and `dout` stays 0 until the edge that captures the seventh new sample. The first median is visible in the cycle that follows that edge.
- R3: Once `dout_valid` is 1, it stays 1 on every cycle until `rst` is asserted again.
- R4: While `dout_valid` is 1, `dout` equals the 4th smallest of the seven most recently captured samples. That value is one of the samples, at most three samples are smaller than it, and at most three are larger.
- R5: Samples are ordered as signed two's complement numbers, so a negative value always ranks below a positive one. For example, the window -9, -4, 0, 3, 8, 12, 20 gives 3.
- R6: Equal values count as separate entries in the ranking. For example, the window -15, 4, 4, 100, -2, 4, 9 gives 4.
- R7: A single large outlier of either sign is rejected. The window 10, 11, 12, 300, 13, 11, 10 gives 11, and the window -8, -7, -6, -200, -5, -7, -6 gives -7.
- R8: A reset in the middle of the stream clears the history. A sample presented while `rst` is high is not captured, and the next valid output again needs seven new samples.
- R9: With the window full, every edge drops the oldest sample and adds the newest. For example, the stream 5, 1, 9, 3, 7, 2, 8, 6, 4 produces 5, 6, 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All state changes on the rising edge. |
| rst | input | 1 | Synchronous reset, active high. Clears the history, the fill count and the outputs. |
| din | input | DW | Signed input sample, captured on every edge while reset is low. |
| dout | output | DW | Signed median of the latest seven samples. Reads 0 when not valid. |
| dout_valid | output | 1 | High when `dout` holds the median of a full window. |

## Verification
The checker watches several properties on every cycle:
- the outputs are quiet after reset, and stay at zero while the fill count is below seven;
- the first valid coincides with the count stepping from six to seven;
- the strobe holds high once it is up;
- exactly one window entry is selected;
- the output is a member of the stored window with at most three entries below it and at most three above it.

The exact signed value, the handling of duplicates and outliers, and the point at which a reset stops a sample from being captured can only be shown by the bench. The bench compares each output against a model that sorts the window. It runs directed windows and a long random stream with occasional resets.

// File: rtl/smf_pkg.sv
package smf_pkg;
  localparam int WIN = 7;
  localparam int MID = (WIN - 1) / 2;
  localparam int CW  = $clog2(WIN + 1);
  typedef logic [CW-1:0] fill_t;
endpackage

// File: rtl/smf_history.sv
module smf_history
  import smf_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DW-1:0]            din,
  output logic [WIN-1:0][DW-1:0]   win_next,
  output logic [WIN-1:0][DW-1:0]   hist_q
);
  // Slot 0 holds the newest sample and slot WIN-1 the oldest.
  assign win_next[0] = din;
  for (genvar i = 1; i < WIN; i++) begin : g_shift
    assign win_next[i] = hist_q[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= win_next;
  end
endmodule

// File: rtl/smf_rank_select.sv
module smf_rank_select
  import smf_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [WIN-1:0][DW-1:0] win,
  output logic [WIN-1:0]         pick,
  output logic [DW-1:0]          median
);
  // Entry a ranks ahead of entry b when it is smaller as a signed number,
  // or when it is equal and sits at a lower index (ties are broken by slot).
  function automatic logic ranks_ahead(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                       input int ia, input int ib);
    return ($signed(a) < $signed(b)) || ((a == b) && (ia < ib));
  endfunction

  for (genvar i = 0; i < WIN; i++) begin : g_rank
    fill_t rank;
    always_comb begin
      rank = '0;
      for (int j = 0; j < WIN; j++) begin
        if (j != i && ranks_ahead(win[j], win[i], j, i)) rank = rank + 1'b1;
      end
    end
    assign pick[i] = (rank == fill_t'(MID));
  end

  always_comb begin
    median = '0;
    for (int i = 0; i < WIN; i++) begin
      if (pick[i]) median = median | win[i];
    end
  end
endmodule

// File: rtl/smf_fill.sv
module smf_fill
  import smf_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output fill_t fill_cnt,
  output logic  full_next
);
  // Set when the capture at this edge fills or keeps filling the window.
  assign full_next = (fill_cnt >= fill_t'(WIN - 1));

  always_ff @(posedge clk) begin
    if (rst)                          fill_cnt <= '0;
    else if (fill_cnt != fill_t'(WIN)) fill_cnt <= fill_cnt + 1'b1;
  end
endmodule

// File: rtl/sliding_median_filter.sv
module sliding_median_filter
  import smf_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_valid
);
  logic [WIN-1:0][DW-1:0] win_next;
  logic [WIN-1:0][DW-1:0] hist_q;
  logic [WIN-1:0]         pick;
  logic [DW-1:0]          median;
  fill_t                  fill_cnt;
  logic                   full_next;

  smf_history #(.DW(DW)) u_hist (
    .clk(clk), .rst(rst), .din(din), .win_next(win_next), .hist_q(hist_q)
  );

  smf_rank_select #(.DW(DW)) u_sel (
    .win(win_next), .pick(pick), .median(median)
  );

  smf_fill u_fill (
    .clk(clk), .rst(rst), .fill_cnt(fill_cnt), .full_next(full_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      dout       <= full_next ? median : '0;
      dout_valid <= full_next;
    end
  end
endmodule

// File: rtl/smf_checker.sv
module smf_checker
  import smf_pkg::*;
#(
  parameter int DW = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic [WIN-1:0][DW-1:0] hist_q,
  input logic [WIN-1:0]         pick,
  input logic [DW-1:0]          dout,
  input logic                   dout_valid,
  input fill_t                  fill_cnt
);
  int   n_below, n_above, n_equal;
  logic past_rst_q = 1'b0;

  always_comb begin
    n_below = 0; n_above = 0; n_equal = 0;
    for (int i = 0; i < WIN; i++) begin
      if ($signed(hist_q[i]) < $signed(dout))      n_below++;
      else if ($signed(hist_q[i]) > $signed(dout)) n_above++;
      else                                         n_equal++;
    end
  end

  always @(posedge clk) past_rst_q <= rst;

  always @(negedge clk) begin
    if (past_rst_q) begin
      AST_RESET_QUIET: assert (!dout_valid && dout == '0); // R1
    end
  end

  AST_FILL_GATE: assert property (@(posedge clk) disable iff (rst)
    (fill_cnt < fill_t'(WIN)) |-> (!dout_valid && dout == '0)); // R2

  AST_FIRST_VALID: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_valid) |-> (fill_cnt == fill_t'(WIN) && $past(fill_cnt) == fill_t'(WIN - 1))); // R2

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    dout_valid |=> dout_valid); // R3

  AST_MEDIAN_RANK: assert property (@(posedge clk) disable iff (rst)
    dout_valid |-> (n_below <= MID && n_above <= MID)); // R4

  AST_MEDIAN_MEMBER: assert property (@(posedge clk) disable iff (rst)
    dout_valid |-> (n_equal > 0)); // R4

  AST_ONE_PICK: assert property (@(posedge clk) disable iff (rst)
    $onehot(pick)); // R6
endmodule

bind sliding_median_filter smf_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .hist_q(hist_q), .pick(pick),
  .dout(dout), .dout_valid(dout_valid), .fill_cnt(fill_cnt)
);

// File: tb/sliding_median_filter_tb.sv
`timescale 1ns/1ps
module sliding_median_filter_tb;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst;
  logic signed [DW-1:0] din;
  logic        [DW-1:0] dout;
  logic                 dout_valid;

  sliding_median_filter #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst), .din(din), .dout(dout), .dout_valid(dout_valid)
  );

  int total = 0;
  int bad   = 0;
  int mh[7];
  int mcnt  = 0;
  bit prev_vld = 0;

  function automatic int sorted_mid(input int w[7]);
    int s[7];
    s = w;
    for (int i = 1; i < 7; i++) begin
      int k = s[i];
      int j = i - 1;
      while (j >= 0 && s[j] > k) begin
        s[j+1] = s[j];
        j--;
      end
      s[j+1] = k;
    end
    return s[3];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic int out_val();
    return int'($signed(dout));
  endfunction

  // Drive one cycle, update the model at the edge, check in the middle of the next cycle.
  task automatic step(input bit r, input int v, input string tag);
    int  vt;
    bit  ev;
    int  em;
    vt  = int'($signed(v[DW-1:0]));
    rst = r;
    din = v[DW-1:0];
    @(posedge clk);
    if (r) begin
      mcnt = 0;
      for (int i = 0; i < 7; i++) mh[i] = 0;
    end else begin
      for (int i = 6; i > 0; i--) mh[i] = mh[i-1];
      mh[0] = vt;
      if (mcnt < 7) mcnt++;
    end
    ev = !r && (mcnt == 7);
    em = ev ? sorted_mid(mh) : 0;
    @(negedge clk);
    if (r) begin
      chk(dout_valid == 1'b0, "R1 valid", int'(dout_valid), 0);
      chk(out_val() == 0, "R1 value", out_val(), 0);
    end else begin
      if (prev_vld) chk(dout_valid == 1'b1, "R3 valid held", int'(dout_valid), 1);
      else          chk(dout_valid == ev, "R2 valid timing", int'(dout_valid), int'(ev));
      chk(out_val() == em, tag, out_val(), em);
    end
    prev_vld = ev;
  endtask

  task automatic run_seq(input int s[], input string tag);
    foreach (s[i]) step(1'b0, s[i], tag);
  endtask

  task automatic do_reset(input int cycles);
    for (int i = 0; i < cycles; i++) step(1'b1, 16'h1234 + i, "R1");
  endtask

  initial begin
    #1_500_000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst = 1'b1;
    din = '0;
    do_reset(3);

    // R5 signed ordering, R2 first-output timing
    run_seq('{-9, -4, 0, 3, 8, 12}, "R2 fill");
    chk(dout_valid == 1'b0, "R2 six samples", int'(dout_valid), 0);
    step(1'b0, 20, "R5");
    chk(out_val() == 3, "R5 literal", out_val(), 3);

    do_reset(1);
    run_seq('{10, 11, 12, 300, 13, 11, 10}, "R7");
    chk(out_val() == 11, "R7 positive spike", out_val(), 11);

    do_reset(2);
    run_seq('{-8, -7, -6, -200, -5, -7, -6}, "R7");
    chk(out_val() == -7, "R7 negative spike", out_val(), -7);

    do_reset(1);
    run_seq('{-15, 4, 4, 100, -2, 4, 9}, "R6");
    chk(out_val() == 4, "R6 duplicates", out_val(), 4);

    do_reset(1);
    run_seq('{5, 1, 9, 3, 7, 2, 8}, "R9");
    chk(out_val() == 5, "R9 window 1", out_val(), 5);
    step(1'b0, 6, "R9");
    chk(out_val() == 6, "R9 window 2", out_val(), 6);
    step(1'b0, 4, "R9");
    chk(out_val() == 6, "R9 window 3", out_val(), 6);

    // R8 mid-stream reset: sample offered during reset is dropped
    step(1'b1, 999, "R8");
    chk(dout_valid == 1'b0, "R8 valid drop", int'(dout_valid), 0);
    run_seq('{-1, -1, -1, -1, -1, -1}, "R8");
    chk(dout_valid == 1'b0, "R8 refill gate", int'(dout_valid), 0);
    step(1'b0, -1, "R8");
    chk(out_val() == -1, "R8 clean window", out_val(), -1);

    // R5 extremes of the signed range
    run_seq('{32767, -32768, 32767, -32768, 32767, -32768, 32767}, "R5");
    chk(out_val() == 32767, "R5 extremes", out_val(), 32767);

    // R4 random stream with occasional resets
    for (int n = 0; n < 4000; n++) begin
      int sel = int'($urandom_range(0, 9));
      int v;
      if (sel < 4)      v = int'($urandom_range(0, 8)) - 4;
      else if (sel < 6) v = ($urandom_range(0, 1) == 0) ? -32768 : 32767;
      else              v = int'($urandom_range(0, 65535)) - 32768;
      if ($urandom_range(0, 199) == 0) step(1'b1, v, "R8");
      else                             step(1'b0, v, "R4");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule